// File: doc/BRIEF.md
# Shift-OR Exact String Matcher

This block scans a byte stream for one fixed character string and reports each place where that string ends. It takes one byte per clock through a valid/ready input. A byte is first reduced to a short symbol code over the set of distinct characters in the string. Code 0 stands for any byte outside that set. The code selects an inverted mask, and the mask folds into an active-low progress vector using the shift-OR rule. A one-cycle match flag rises when the whole string has just been seen.

The string is the `PATTERN` parameter: a packed vector of `PAT_LEN` bytes, with the first character in the most significant byte. The symbol codes and masks are computed from it at elaboration. Back-pressure is simple. `in_ready_o` is high in every cycle except one in which `flush_i` is high. A byte is consumed only in a cycle where `in_valid_i` and `in_ready_o` are both high. A producer may hold or drop `in_valid_i` at will, and a byte offered during a flush cycle is not consumed.

Top module: `shiftor_matcher`

## Requirements
- R1: After `rst_i` is released, `match_o` is 0, `in_ready_o` is 1, and no partial progress is kept: the first `PAT_LEN` accepted bytes are needed before any match.
- R2: When an accepted byte completes the string (the last `PAT_LEN` accepted bytes equal `PATTERN`), `match_o` is 1 in the cycle after the acceptance edge. In every other cycle it is 0.
- R3: Matches that overlap are all reported. With the default string "aaba", the input "aabaaba" gives a pulse after the 4th and after the 7th byte.
- R4: A byte that differs in any of its 8 bits from every character of the string ends all partial progress. This includes a case variant or the same code with bit 7 set. For "aaba", the input "aac" followed by "aba" gives no match.
- R5: In a cycle with `in_valid_i` low, no byte is consumed, the progress is kept, and `match_o` is 0 in the next cycle.
- R6: `flush_i` high for one cycle restores the reset progress. In that cycle `in_ready_o` is 0, any offered byte is dropped, and `match_o` is 0 in the next cycle.
- R7: With `flush_i` low, `in_ready_o` is 1. The block never stalls the stream otherwise.
- R8: A match is reported only when at least `PAT_LEN` bytes have been accepted since the last reset or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| flush_i | input | 1 | Synchronous restart of the search, active high |
| in_valid_i | input | 1 | Input byte is valid |
| in_ready_o | output | 1 | Block can take a byte this cycle |
| in_byte_i | input | 8 | Input byte |
| match_o | output | 1 | One-cycle flag: string just completed |

## Verification
The bench sweeps every 7-byte text over an alphabet of both string characters plus one outsider, for the self-overlapping string "aaba". Some texts carry idle bubbles between bytes. A design that reset its progress after a hit would lose the second of two overlapping matches. A design that mishandled the outsider code would keep stale prefixes and fire late. Directed sequences cover case variants and high-bit aliases of a string character, which an encoder comparing too few bits would accept. They also cover a flush that arrives with a valid byte, which a design would wrongly consume, and idle cycles, which a design would wrongly shift on.

// File: rtl/smatch_pkg.sv
package smatch_pkg;

  localparam int MAX_LEN = 64;
  typedef logic [8*MAX_LEN-1:0] pat_t;

  // character at 0-based position i (position 0 is the first character)
  function automatic logic [7:0] pat_char(input pat_t p, input int len, input int i);
    return p[8*(len-1-i) +: 8];
  endfunction

  // true when position i holds the first occurrence of its character
  function automatic bit is_first(input pat_t p, input int len, input int i);
    bit first = 1'b1;
    for (int j = 0; j < i; j++)
      if (pat_char(p, len, j) == pat_char(p, len, i)) first = 1'b0;
    return first;
  endfunction

  // dense symbol code (1..alphabet) of the character at position i
  function automatic int sym_rank(input pat_t p, input int len, input int i);
    int f = 0;
    int r = 0;
    bit found = 1'b0;
    for (int j = 0; j <= i; j++)
      if (!found && pat_char(p, len, j) == pat_char(p, len, i)) begin
        f = j;
        found = 1'b1;
      end
    for (int j = 0; j <= f; j++)
      if (is_first(p, len, j)) r++;
    return r;
  endfunction

  function automatic int alpha_size(input pat_t p, input int len);
    int n = 0;
    for (int j = 0; j < len; j++)
      if (is_first(p, len, j)) n++;
    return n;
  endfunction

endpackage

// File: rtl/smatch_encoder.sv
module smatch_encoder
  import smatch_pkg::*;
#(
  parameter int                   PAT_LEN = 4,
  parameter logic [8*PAT_LEN-1:0] PATTERN = "aaba",
  parameter int                   CODE_W  = 2
) (
  input  logic [7:0]        byte_i,
  output logic [CODE_W-1:0] code_o
);
  localparam pat_t PFULL = pat_t'(PATTERN);

  logic [CODE_W-1:0] hit [PAT_LEN];

  for (genvar i = 0; i < PAT_LEN; i++) begin : g_pos
    if (is_first(PFULL, PAT_LEN, i)) begin : g_sym
      localparam logic [7:0]        CH = pat_char(PFULL, PAT_LEN, i);
      localparam logic [CODE_W-1:0] RK = CODE_W'(sym_rank(PFULL, PAT_LEN, i));
      assign hit[i] = (byte_i == CH) ? RK : '0;
    end else begin : g_dup
      assign hit[i] = '0;
    end
  end

  // at most one distinct symbol can hit, so OR merges the codes
  always_comb begin
    code_o = '0;
    for (int i = 0; i < PAT_LEN; i++) code_o |= hit[i];
  end
endmodule

// File: rtl/smatch_mask.sv
module smatch_mask
  import smatch_pkg::*;
#(
  parameter int                   PAT_LEN = 4,
  parameter logic [8*PAT_LEN-1:0] PATTERN = "aaba",
  parameter int                   CODE_W  = 2
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [PAT_LEN-1:0] mask_o
);
  localparam pat_t PFULL  = pat_t'(PATTERN);
  localparam int   NCODES = 1 << CODE_W;

  logic [PAT_LEN-1:0] tbl [NCODES];

  // bit k is 0 when the code equals the character at position k
  for (genvar c = 0; c < NCODES; c++) begin : g_code
    for (genvar k = 0; k < PAT_LEN; k++) begin : g_bit
      localparam bit SEL = (c != 0) && (sym_rank(PFULL, PAT_LEN, k) == c);
      assign tbl[c][k] = SEL ? 1'b0 : 1'b1;
    end
  end

  assign mask_o = tbl[code_i];
endmodule

// File: rtl/smatch_state.sv
module smatch_state #(
  parameter int PAT_LEN = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               flush_i,
  input  logic               adv_i,
  input  logic [PAT_LEN-1:0] mask_i,
  output logic               match_o
);
  // prog_q[k] holds progress bit k+1; bit 0 is a constant 0 and is not stored
  logic [PAT_LEN-1:0] prog_q, prog_d;
  logic               match_q;

  always_comb begin
    prog_d[0] = mask_i[0];
    for (int k = 1; k < PAT_LEN; k++) prog_d[k] = prog_q[k-1] | mask_i[k];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) begin
      prog_q  <= '1;
      match_q <= 1'b0;
    end else if (adv_i) begin
      prog_q  <= prog_d;
      match_q <= ~prog_d[PAT_LEN-1];
    end else begin
      match_q <= 1'b0;
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/shiftor_matcher.sv
module shiftor_matcher
  import smatch_pkg::*;
#(
  parameter int                   PAT_LEN = 4,
  parameter logic [8*PAT_LEN-1:0] PATTERN = "aaba"
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       flush_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [7:0] in_byte_i,
  output logic       match_o
);
  localparam int ALPHA  = alpha_size(pat_t'(PATTERN), PAT_LEN);
  localparam int CODE_W = (ALPHA + 1 > 2) ? $clog2(ALPHA + 1) : 1;

  logic [CODE_W-1:0]  code;
  logic [PAT_LEN-1:0] mask;
  logic               adv;

  assign in_ready_o = ~flush_i;
  assign adv        = in_valid_i & in_ready_o;

  smatch_encoder #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN), .CODE_W(CODE_W)) u_enc (
    .byte_i (in_byte_i),
    .code_o (code)
  );

  smatch_mask #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN), .CODE_W(CODE_W)) u_mask (
    .code_i (code),
    .mask_o (mask)
  );

  smatch_state #(.PAT_LEN(PAT_LEN)) u_state (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .flush_i (flush_i),
    .adv_i   (adv),
    .mask_i  (mask),
    .match_o (match_o)
  );
endmodule

// File: rtl/shiftor_matcher_chk.sv
module shiftor_matcher_chk #(
  parameter int PAT_LEN = 4
) (
  input logic clk_i,
  input logic rst_i,
  input logic flush_i,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic match_o
);
  localparam int CW = $clog2(PAT_LEN + 1) + 1;
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) seen_q <= '0;
    else if (in_valid_i && in_ready_o && seen_q < CW'(PAT_LEN)) seen_q <= seen_q + 1'b1;
  end

  // R5
  idle_no_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> !match_o);

  // R6
  flush_no_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> !match_o);

  // R6
  flush_blocks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |-> !in_ready_o);

  // R7
  ready_open_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !flush_i |-> in_ready_o);

  // R8
  enough_bytes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    match_o |-> (seen_q >= CW'(PAT_LEN)));
endmodule

bind shiftor_matcher shiftor_matcher_chk #(.PAT_LEN(PAT_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .flush_i    (flush_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .match_o    (match_o)
);

// File: tb/sim_shiftor_matcher.sv
`timescale 1ns/1ps
module sim_shiftor_matcher;
  localparam int             M   = 4;
  localparam logic [8*M-1:0] PAT = "aaba";

  logic       clk = 1'b0;
  logic       rst, flush, vld;
  logic [7:0] din;
  logic       rdy, match;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [8*M-1:0] hist;
  int             seen;

  always #10 clk = ~clk;

  shiftor_matcher #(.PAT_LEN(M), .PATTERN(PAT)) u0 (
    .clk_i(clk), .rst_i(rst), .flush_i(flush), .in_valid_i(vld),
    .in_ready_o(rdy), .in_byte_i(din), .match_o(match)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    hist = '0;
    seen = 0;
  endtask

  // one cycle: drive at negedge, check ready, clock, check match at next negedge
  task automatic step(input string tag, input logic v, input logic [7:0] b, input logic f);
    logic exp_m;
    vld   = v;
    din   = b;
    flush = f;
    #1;
    chk({tag, " ready (R6/R7)"}, rdy, ~f);
    exp_m = 1'b0;
    if (f) model_clear();
    else if (v) begin
      hist = {hist[8*(M-1)-1:0], b};
      if (seen < M) seen++;
      exp_m = (seen >= M) && (hist == PAT);
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, match, exp_m);
  endtask

  task automatic send(input string tag, input string s);
    for (int i = 0; i < s.len(); i++) step(tag, 1'b1, s[i], 1'b0);
  endtask

  task automatic expect_m(input string tag, input logic exp);
    chk(tag, match, exp);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 1'b0; vld = 1'b0; din = 8'h00;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 match after reset", match, 1'b0);
    chk("R1 ready after reset", rdy, 1'b1);
    send("R1 prefix only", "aab");

    // R2 basic match and R3 overlap
    step("R2 flush", 1'b0, 8'h00, 1'b1);
    send("R2 single", "aaba");
    step("R2 pulse ends", 1'b0, 8'h00, 1'b0);
    send("R3 overlap", "aba");
    send("R3 tail", "aaba");

    // R4 outsider bytes, case variant, bit-7 alias
    step("R4 flush", 1'b0, 8'h00, 1'b1);
    send("R4 outsider", "aacaba");
    send("R4 upper", "aAba");
    send("R4 high bit", "a");
    step("R4 high bit", 1'b1, 8'hE1, 1'b0);
    send("R4 high bit", "ba");

    // R5 idle cycles keep progress
    step("R5 flush", 1'b0, 8'h00, 1'b1);
    send("R5 part", "aa");
    step("R5 idle", 1'b0, "b", 1'b0);
    step("R5 idle", 1'b0, "a", 1'b0);
    send("R5 resume", "ba");

    // R6 flush with a valid byte offered: byte dropped, progress lost
    send("R6 part", "aab");
    step("R6 flush valid", 1'b1, "a", 1'b1);
    send("R6 after", "a");
    send("R6 after", "aba");

    // R8 sweep: every 7-byte text over {a,b,c}, bubbles in some
    for (int s = 0; s < 2187; s++) begin
      int v;
      v = s;
      step("R8 sweep flush", 1'b0, 8'h00, 1'b1);
      for (int k = 0; k < 7; k++) begin
        logic [7:0] ch;
        ch = 8'h61 + 8'(v % 3);
        v = v / 3;
        if ((s % 5 == 0) && (k == 3)) step("R5 sweep bubble", 1'b0, ch, 1'b0);
        step("R2 R3 R4 sweep", 1'b1, ch, 1'b0);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule